// File: doc/BRIEF.md
# Two-Wire Master Serial Clock Generator with Bus Synchronization

This block produces the serial clock of a two-wire bus master. It does not drive the line high itself. It only asserts a pull-low enable for an open-drain pad, and it watches the line level that returns from the pad. Two programmable counts, in system clock cycles, set how long the block holds the line low and how long it leaves it released and high. After each low phase the block lets go of the line. It starts timing the high phase only once a synchronized copy of the line actually reads high. A slave or a slower master that keeps the line low therefore stretches the low phase. A faster master that pulls the line low early cuts the high phase short.

A transfer runs while the master enable and the transfer request are both high and arbitration has not been lost. The block then cycles low and high phases one bit at a time. It stops at the end of a high phase once the request has been withdrawn. A lost arbitration or a dropped enable releases the line at once and sends the block back to idle.

Rise and fall strobes mark the start of each high phase and each low phase. A per-bit tick in the middle of each low phase tells a neighbouring data shifter when to change the data line.

Top module: `scl_sync_gen`

## Requirements
- R1: After reset the pull-low enable, busy flag, rise strobe, fall strobe and bit tick are all 0. While busy is 0, the pull-low enable and bit tick stay 0.
- R2: While master_en is 0, a held xfer_req has no effect: the pull-low enable and busy stay 0.
- R3: Each low phase asserts scl_pull_low for exactly lo_count cycles. scl_fall is 1 in the first of those cycles.
- R4: After releasing the line, the block waits until its synchronized line copy reads 1. It then times the high phase. With two synchronizer stages and a line that rises at once, the released span is hi_count + 3 cycles. When another device holds the line low longer, the released span still runs hi_count + 3 cycles from the moment the line actually goes high.
- R5: When the high count expires and xfer_req is still 1, scl_pull_low rises on the next cycle, with scl_fall.
- R6: If the line is seen low during a high phase before the count expires, the block starts its own low phase. scl_pull_low rises on the third clock edge after the line falls (two synchronizer edges plus one state edge), and a full lo_count low phase follows.
- R7: scl_pull_low is 0 in any cycle where arb_lost is 1. busy is 0 from the next cycle on, and the block stays idle until arb_lost returns to 0.
- R8: scl_pull_low is 0 in any cycle where master_en is 0. busy is 0 from the next cycle on.
- R9: scl_rise is a single-cycle strobe in the first high-phase cycle, three cycles into the released span. It never coincides with scl_fall or scl_pull_low.
- R10: bit_tick pulses once per low phase, at cycle offset ceil((N-1)/2) from the start of the low phase, where N is the effective low count. It is only ever 1 while scl_pull_low is 1.
- R11: If xfer_req is 0 when a high count expires, the block goes idle and leaves the line released.
- R12: A count value of 0 acts as 1: a one-cycle low phase and a one-cycle high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master mode enable; 0 releases the line and idles the block |
| xfer_req | input | 1 | Level request to run clock bits |
| arb_lost | input | 1 | Arbitration lost; releases the line in the same cycle |
| scl_in | input | 1 | Raw level of the bus clock line |
| hi_count | input | CNT_W | High-phase length in cycles (0 acts as 1) |
| lo_count | input | CNT_W | Low-phase length in cycles (0 acts as 1) |
| scl_pull_low | output | 1 | Open-drain pull-low enable for the clock pad |
| scl_rise | output | 1 | One-cycle strobe at the start of a high phase |
| scl_fall | output | 1 | One-cycle strobe at the start of a low phase |
| busy | output | 1 | Block is not idle |
| bit_tick | output | 1 | Mid-low-phase tick for the data shifter |

## Verification
The bench builds the block with the defaults: 8-bit counts and a two-stage synchronizer. This fixes the wait after each release at three cycles, so every released span can be predicted exactly from hi_count. The 8-bit counts cover zero values, short phases such as 3 and 6, and a 40-cycle high phase. The long high phase leaves time for a second device to pull the line low partway through. The bench models the bus as a wired-AND of the block's pull-low and a second device's pull-low, so both stretching and early termination are driven through scl_in.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_HIGH = 2'd2,
      PH_LOW  = 2'd3
   } scl_phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_sync = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2:0], line_in};
         end
         assign line_sync = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear,
   output logic             expired,
   output logic             at_mid
);

   logic [CNT_W-1:0] cnt_q, half_q, eff;

   assign eff = (load_val == '0) ? CNT_W'(1) : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
         half_q <= '0;
      end else if (load) begin
         cnt_q  <= eff - CNT_W'(1);
         half_q <= (eff - CNT_W'(1)) >> 1;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);
   assign at_mid  = (cnt_q == half_q);

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
   import scl_gen_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_en,
   input  logic             xfer_req,
   input  logic             arb_lost,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] hi_count,
   input  logic [CNT_W-1:0] lo_count,
   output logic             scl_pull_low,
   output logic             scl_rise,
   output logic             scl_fall,
   output logic             busy,
   output logic             bit_tick
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("scl_sync_gen: CNT_W must be at least 2");
      end
      if (SYNC_STAGES != 0 && SYNC_STAGES < 2) begin : g_bad_sync
         $error("scl_sync_gen: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   scl_phase_e state_q, state_d;
   logic       line_s;
   logic       ok;
   logic       load_hi, load_lo;
   logic       t_expired, t_mid;
   logic       seen_low_q;
   logic       rise_q, fall_q;

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (scl_in),
      .line_sync (line_s)
   );

   scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_hi | load_lo),
      .load_val (load_hi ? hi_count : lo_count),
      .clear    (state_d == PH_IDLE),
      .expired  (t_expired),
      .at_mid   (t_mid)
   );

   assign ok = master_en & ~arb_lost;

   always_comb begin
      state_d = state_q;
      load_hi = 1'b0;
      load_lo = 1'b0;
      unique case (state_q)
         PH_IDLE: if (xfer_req) state_d = PH_WAIT;
         PH_WAIT: if (seen_low_q && line_s) begin
            state_d = PH_HIGH;
            load_hi = 1'b1;
         end
         PH_HIGH: begin
            if (!line_s) begin
               state_d = PH_LOW;
               load_lo = 1'b1;
            end else if (t_expired) begin
               if (xfer_req) begin
                  state_d = PH_LOW;
                  load_lo = 1'b1;
               end else begin
                  state_d = PH_IDLE;
               end
            end
         end
         PH_LOW:  if (t_expired) state_d = PH_WAIT;
         default: state_d = PH_IDLE;
      endcase
      if (!ok) begin
         state_d = PH_IDLE;
         load_hi = 1'b0;
         load_lo = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PH_IDLE;
         seen_low_q <= 1'b0;
         rise_q     <= 1'b0;
         fall_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         rise_q  <= (state_q == PH_WAIT) && (state_d == PH_HIGH);
         fall_q  <= (state_q == PH_HIGH) && (state_d == PH_LOW);
         if (state_q == PH_IDLE && state_d == PH_WAIT)
            seen_low_q <= 1'b1;
         else if (state_q != PH_LOW && state_d == PH_LOW)
            seen_low_q <= 1'b0;
         else if ((state_q == PH_LOW || state_q == PH_WAIT) && !line_s)
            seen_low_q <= 1'b1;
      end
   end

   assign scl_pull_low = (state_q == PH_LOW) & ok;
   assign scl_rise     = rise_q;
   assign scl_fall     = fall_q;
   assign busy         = (state_q != PH_IDLE);
   assign bit_tick     = (state_q == PH_LOW) & ok & t_mid;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk #(
   parameter int CNT_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic master_en,
   input logic arb_lost,
   input logic scl_pull_low,
   input logic scl_rise,
   input logic scl_fall,
   input logic busy,
   input logic bit_tick
);

   localparam int MAX_RUN = 1 << CNT_W;

   int run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= 0;
      else if (scl_pull_low) run_q <= run_q + 1;
      else                   run_q <= 0;
   end

   // R7
   arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> !scl_pull_low);
   // R7
   arb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !busy);
   // R8
   en_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> !scl_pull_low);
   // R8
   en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !busy);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_pull_low && !bit_tick));
   // R3
   pull_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull_low) |-> scl_fall);
   // R3
   low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= MAX_RUN);
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scl_rise, scl_fall}));
   // R9
   rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> !scl_pull_low);
   // R10
   tick_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> scl_pull_low);

endmodule

bind scl_sync_gen scl_sync_gen_chk #(.CNT_W(CNT_W)) u_scl_sync_gen_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .master_en    (master_en),
   .arb_lost     (arb_lost),
   .scl_pull_low (scl_pull_low),
   .scl_rise     (scl_rise),
   .scl_fall     (scl_fall),
   .busy         (busy),
   .bit_tick     (bit_tick)
);

// File: tb/test_scl_sync_gen.sv
module test_scl_sync_gen;

   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_en = 1'b0;
   logic          xfer_req = 1'b0;
   logic          arb_lost = 1'b0;
   logic          other_low = 1'b0;
   logic [CW-1:0] hi_count = 8'd4;
   logic [CW-1:0] lo_count = 8'd6;
   logic          scl_in;
   logic          scl_pull_low, scl_rise, scl_fall, busy, bit_tick;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   assign scl_in = ~(scl_pull_low | other_low);

   scl_sync_gen #(.CNT_W(CW), .SYNC_STAGES(2)) i_scl_sync_gen (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .xfer_req(xfer_req),
      .arb_lost(arb_lost), .scl_in(scl_in), .hi_count(hi_count),
      .lo_count(lo_count), .scl_pull_low(scl_pull_low), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .busy(busy), .bit_tick(bit_tick)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic sync_fall(input string req);
      bit found = 0;
      for (int i = 0; i < 600 && !found; i++) begin
         @(negedge clk);
         if (scl_fall) found = 1;
      end
      check({req, " fall strobe seen"}, int'(found), 1);
   endtask

   task automatic wait_rise(input string req);
      bit found = 0;
      for (int i = 0; i < 600 && !found; i++) begin
         @(negedge clk);
         if (scl_rise) found = 1;
      end
      check({req, " rise strobe seen"}, int'(found), 1);
   endtask

   task automatic measure(output int lo, output int hi, output int rise_idx,
                          output int tick_idx, output int ticks);
      lo = 0; hi = 0; rise_idx = -1; tick_idx = -1; ticks = 0;
      while (scl_pull_low && lo < 1000) begin
         if (bit_tick) begin ticks++; tick_idx = lo; end
         lo++;
         @(negedge clk);
      end
      while (!scl_pull_low && hi < 1000) begin
         if (scl_rise) rise_idx = hi;
         hi++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check("R1 pull after reset", int'(scl_pull_low), 0);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 strobes after reset", int'({scl_rise, scl_fall, bit_tick}), 0);
   endtask

   task automatic t_disabled;
      int pulls = 0, busies = 0;
      master_en = 1'b0;
      xfer_req  = 1'b1;
      repeat (20) begin
         @(negedge clk);
         pulls  += int'(scl_pull_low);
         busies += int'(busy);
      end
      check("R2 no pull while disabled", pulls, 0);
      check("R2 no busy while disabled", busies, 0);
   endtask

   task automatic t_normal;
      int lo, hi, ri, ti, tc;
      hi_count = 8'd4; lo_count = 8'd6;
      master_en = 1'b1; xfer_req = 1'b1;
      sync_fall("R5");
      for (int k = 0; k < 2; k++) begin
         check("R3 fall strobe at low start", int'(scl_fall), 1);
         measure(lo, hi, ri, ti, tc);
         check("R3 low length", lo, 6);
         check("R4 R5 released length", hi, 7);
         check("R9 rise offset", ri, 3);
         check("R10 tick count", tc, 1);
         check("R10 tick offset", ti, 3);
      end
   endtask

   task automatic t_zero;
      int lo, hi, ri, ti, tc;
      hi_count = 8'd0; lo_count = 8'd0;
      sync_fall("R12");
      sync_fall("R12");
      measure(lo, hi, ri, ti, tc);
      check("R12 zero low count", lo, 1);
      check("R12 zero high count", hi, 4);
      check("R12 R10 tick offset", ti, 0);
   endtask

   task automatic t_stretch;
      int lo = 0, total = 0, hi = 0;
      hi_count = 8'd2; lo_count = 8'd3;
      sync_fall("R4");
      sync_fall("R4");
      other_low = 1'b1;
      while (total < 8) begin
         lo += int'(scl_pull_low);
         total++;
         @(negedge clk);
      end
      other_low = 1'b0;
      while (!scl_pull_low && hi < 1000) begin
         hi++;
         @(negedge clk);
      end
      check("R3 own low while stretched", lo, 3);
      check("R4 high after stretch", hi, 5);
   endtask

   task automatic t_early;
      int lo, hi, ri, ti, tc;
      hi_count = 8'd40; lo_count = 8'd5;
      sync_fall("R6");
      sync_fall("R6");
      wait_rise("R6");
      repeat (4) @(negedge clk);
      other_low = 1'b1;
      @(negedge clk);
      check("R6 no pull after 1 edge", int'(scl_pull_low), 0);
      @(negedge clk);
      check("R6 no pull after 2 edges", int'(scl_pull_low), 0);
      @(negedge clk);
      check("R6 pull after 3 edges", int'(scl_pull_low), 1);
      check("R6 fall strobe", int'(scl_fall), 1);
      other_low = 1'b0;
      measure(lo, hi, ri, ti, tc);
      check("R6 full low after early end", lo, 5);
      check("R6 R4 next high", hi, 43);
   endtask

   task automatic t_arb;
      int pulls = 0;
      hi_count = 8'd4; lo_count = 8'd6;
      sync_fall("R7");
      @(negedge clk);
      arb_lost = 1'b1;
      #1;
      check("R7 same-cycle release", int'(scl_pull_low), 0);
      @(negedge clk);
      check("R7 idle next cycle", int'(busy), 0);
      repeat (10) begin
         @(negedge clk);
         pulls += int'(scl_pull_low) + int'(busy);
      end
      check("R7 stays released", pulls, 0);
      arb_lost = 1'b0;
      sync_fall("R7 restart");
   endtask

   task automatic t_enable;
      sync_fall("R8");
      @(negedge clk);
      master_en = 1'b0;
      #1;
      check("R8 same-cycle release", int'(scl_pull_low), 0);
      @(negedge clk);
      check("R8 idle next cycle", int'(busy), 0);
      master_en = 1'b1;
   endtask

   task automatic t_req_off;
      int pulls = 0;
      hi_count = 8'd4; lo_count = 8'd6;
      sync_fall("R11");
      wait_rise("R11");
      xfer_req = 1'b0;
      repeat (5) @(negedge clk);
      check("R11 idle after high expiry", int'(busy), 0);
      repeat (20) begin
         @(negedge clk);
         pulls += int'(scl_pull_low);
      end
      check("R11 line stays released", pulls, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_normal();
      t_zero();
      t_stretch();
      t_early();
      t_arb();
      t_enable();
      t_req_off();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule